// File: doc/BRIEF.md
# I/O interrupt redirection controller

This block takes a bank of external interrupt lines and turns each request into a single interrupt message for the processor side. Every line owns a 64-bit redirection entry. The entry holds the vector, the delivery mode, the destination and its addressing mode, the trigger mode, the input polarity, a mask, and a read-only remote-acknowledge flag. Software reaches all of this through two registers on a simple 32-bit memory-mapped bus. It first writes an index into a select register, then reads or writes the addressed register through a window.

A per-line request register records pending work. A lowest-index-first scan launches one message at a time on a valid/ready delivery port. An edge-triggered line drops its request when its message is launched. A level-triggered line instead raises its remote-acknowledge flag and stays quiet until an end-of-interrupt with the same vector arrives on the broadcast input. If the line is still active at that point, it is serviced again.

Top module: `irq_redir_ctrl`

## Requirements
- R1: When the polarity bit (entry bit 13) is set, the line's input is inverted before any trigger logic sees it. A falling input then counts as the active transition.
- R2: For a level-triggered line (entry bit 15 = 1), the request bit follows the active input every cycle. A request that goes inactive before it is delivered is lost.
- R3: Input 0 feeds line 2, together with input 2 through an OR. Every other input n feeds line n. Line 0 has no source and never requests.
- R4: An edge-triggered line (bit 15 = 0) sets its request only on an inactive-to-active transition while its mask bit (bit 16) is clear. A transition seen while masked is dropped and is not recovered by unmasking later. An input held active requests once.
- R5: When several unmasked lines are pending, their messages go out in ascending line order.
- R6: A message carries:
  - the destination from entry bits 63:56;
  - the destination mode from bit 11;
  - the delivery mode from bits 10:8;
  - the vector from bits 7:0;
  - the trigger mode from bit 15.
- R7: Launching a level-triggered message sets remote-acknowledge (bit 14, read-only, reads back as 1). That line sends nothing more until an end-of-interrupt whose vector equals the entry's vector clears the flag. A non-matching vector leaves the flag set. If the line is still active after the flag clears, it is delivered again.
- R8: Launching an edge-triggered message clears that line's request, so each active transition yields exactly one message.
- R9: While the message is valid and ready is low, the message and its valid flag hold unchanged.
- R10: Window index 0x00 holds a 4-bit controller ID in bits 27:24, with all other bits reading 0. Index 0x01 reads (lines − 1) in bits 23:16 and the version code 0x20 in bits 7:0. Index 0x02 reads 0. Writes to indices 0x01 and 0x02 have no effect.
- R11: The select register sits at bus offset 0x00 and reads back its 8-bit value. The window sits at offset 0x10. Only address bits 7:0 are decoded. Entry n occupies index 0x10+2n (bits 31:0) and 0x10+2n+1 (bits 63:32). Writing either half leaves the other half unchanged.
- R12: A window access that is not a 32-bit access is ignored, and such a read returns 0. A read of an index with no register behind it returns 0, as does a read of any other bus offset.
- R13: After reset, every entry is masked with all other fields 0, the ID and select register are 0, and no message is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Raw interrupt inputs |
| bus_addr | input | ADDR_W | Bus byte address; only bits 7:0 are decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | High when the access is a full 32-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| dlv_valid | output | 1 | Interrupt message valid |
| dlv_ready | input | 1 | Processor side accepts the message |
| dlv_dest | output | 8 | Message destination |
| dlv_dest_mode | output | 1 | Destination addressing mode |
| dlv_mode | output | 3 | Delivery mode |
| dlv_vector | output | 8 | Interrupt vector |
| dlv_level | output | 1 | 1 for a level-triggered message |

## Verification
The properties assume that each input is stable around the clock edge and that the polarity of a line is changed only while its input sits at the level that is inactive after the change. Otherwise the edge history would see a legitimate spurious transition. They also assume that the delivery side may hold ready low for any length of time and that end-of-interrupt vectors are arbitrary. The stimulus drives every input, bus strobe and broadcast half a period away from the active edge. It programs polarity only with the input already at its new idle level. It sweeps every line through configuration, readback and delivery while masking lines that carry unrelated patterns, so no stray message reaches a later check.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    // bus offsets and fixed window indices
    localparam logic [7:0] OFS_SEL = 8'h00;
    localparam logic [7:0] OFS_WIN = 8'h10;
    localparam logic [7:0] IDX_ID  = 8'h00;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_ARB = 8'h02;

    // stored portion of a redirection entry (only bits that carry state)
    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       level;
        logic       rack;
        logic       pol;
        logic       dst_logical;
        logic [2:0] dmode;
        logic [7:0] vec;
    } entry_t;

    typedef struct packed {
        logic [7:0] dest;
        logic       dst_logical;
        logic [2:0] dmode;
        logic [7:0] vec;
        logic       level;
    } msg_t;

    typedef struct packed {
        logic [7:0]  sel;
        logic [3:0]  id;
        logic [31:0] rdata;
        logic        dv;
        msg_t        msg;
    } ctl_t;

    function automatic entry_t entry_rst();
        entry_t e;
        e      = '0;
        e.mask = 1'b1;
        return e;
    endfunction

    // bits 31:0 as seen through the window
    function automatic logic [31:0] entry_lo(entry_t e);
        return {15'd0, e.mask, e.level, e.rack, e.pol, 1'b0,
                e.dst_logical, e.dmode, e.vec};
    endfunction

    // bits 63:32 as seen through the window
    function automatic logic [31:0] entry_hi(entry_t e);
        return {e.dest, 24'd0};
    endfunction

endpackage

// File: rtl/irq_redir_cond.sv
// Per-line input conditioning: polarity, edge history and next request bit.
module irq_redir_cond #(
    parameter bit HAS_SRC = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol,
    input  logic level,
    input  logic mask,
    input  logic req_q,
    input  logic served,
    output logic req_d
);
    logic prev_d, prev_q;
    logic active, rise;

    always_comb begin
        active = HAS_SRC ? (raw ^ pol) : 1'b0;
        rise   = active & ~prev_q;
        prev_d = active;
        if (level) begin
            req_d = active;
        end else begin
            // a new transition wins over a same-cycle launch clear
            req_d = (req_q & ~served) | (rise & ~mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_redir_pick.sv
// Lowest-index-first selection among eligible lines.
module irq_redir_pick #(
    parameter int N  = 24,
    parameter int IW = 5
) (
    input  logic [N-1:0]  elig,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        grant = elig & (~elig + {{(N-1){1'b0}}, 1'b1});
        any   = |elig;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
    import irq_redir_pkg::*;
#(
    parameter int         NUM_LINES = 24,
    parameter int         ADDR_W    = 12,
    parameter logic [7:0] TBL_BASE  = 8'h10,
    parameter logic [7:0] VER_CODE  = 8'h20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic                 bus_word,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 eoi_valid,
    input  logic [7:0]           eoi_vector,
    output logic                 dlv_valid,
    input  logic                 dlv_ready,
    output logic [7:0]           dlv_dest,
    output logic                 dlv_dest_mode,
    output logic [2:0]           dlv_mode,
    output logic [7:0]           dlv_vector,
    output logic                 dlv_level
);
    localparam int IW       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int TBL_SPAN = 2 * NUM_LINES;

    ctl_t   ctl_d, ctl_q;
    entry_t tbl_d [NUM_LINES];
    entry_t tbl_q [NUM_LINES];

    logic [NUM_LINES-1:0] irr_d, irr_q, req_next, raw;
    logic [NUM_LINES-1:0] mask_v, level_v, pol_v, elig, grant, served;
    logic [IW-1:0]        pick_idx;
    logic                 pick_any, launch;
    logic                 sel_hit, win_hit, in_tbl, hi_half;
    logic [7:0]           sel_off;
    logic [31:0]          rd_val;
    logic                 addr_unused, wdata_unused;

    assign addr_unused  = ^bus_addr[ADDR_W-1:8];
    assign wdata_unused = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12]};

    // per-line conditioning
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign mask_v[i]  = tbl_q[i].mask;
        assign level_v[i] = tbl_q[i].level;
        assign pol_v[i]   = tbl_q[i].pol;
        assign elig[i]    = irr_q[i] & ~tbl_q[i].mask & ~(tbl_q[i].level & tbl_q[i].rack);
        if (i == 2) begin : g_merge
            assign raw[i] = irq_in[0] | irq_in[2];
        end else begin : g_direct
            assign raw[i] = irq_in[i];
        end
        irq_redir_cond #(.HAS_SRC(i != 0)) u_cond (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (raw[i]),
            .pol    (pol_v[i]),
            .level  (level_v[i]),
            .mask   (mask_v[i]),
            .req_q  (irr_q[i]),
            .served (served[i]),
            .req_d  (req_next[i])
        );
    end

    irq_redir_pick #(.N(NUM_LINES), .IW(IW)) u_pick (
        .elig  (elig),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    assign launch = pick_any & (~ctl_q.dv | dlv_ready);
    assign served = launch ? grant : '0;

    always_comb begin
        ctl_d = ctl_q;
        tbl_d = tbl_q;
        irr_d = req_next;

        sel_hit = (bus_addr[7:0] == OFS_SEL);
        win_hit = (bus_addr[7:0] == OFS_WIN);
        sel_off = ctl_q.sel - TBL_BASE;
        in_tbl  = (ctl_q.sel >= TBL_BASE) && (int'(sel_off) < TBL_SPAN);
        hi_half = sel_off[0];

        // window read value
        rd_val = '0;
        case (ctl_q.sel)
            IDX_ID:  rd_val = {4'd0, ctl_q.id, 24'd0};
            IDX_VER: rd_val = {8'd0, 8'(NUM_LINES - 1), 8'd0, VER_CODE};
            IDX_ARB: rd_val = '0;
            default: begin
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (in_tbl && int'(sel_off[7:1]) == i)
                        rd_val = hi_half ? entry_hi(tbl_q[i]) : entry_lo(tbl_q[i]);
                end
            end
        endcase

        if (bus_rd) begin
            if (sel_hit)                    ctl_d.rdata = {24'd0, ctl_q.sel};
            else if (win_hit && bus_word)   ctl_d.rdata = rd_val;
            else                            ctl_d.rdata = '0;
        end

        if (bus_wr && sel_hit) ctl_d.sel = bus_wdata[7:0];

        if (bus_wr && win_hit && bus_word) begin
            if (ctl_q.sel == IDX_ID) begin
                ctl_d.id = bus_wdata[27:24];
            end else if (ctl_q.sel != IDX_VER && ctl_q.sel != IDX_ARB && in_tbl) begin
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (int'(sel_off[7:1]) == i) begin
                        if (hi_half) begin
                            tbl_d[i].dest = bus_wdata[31:24];
                        end else begin
                            tbl_d[i].vec         = bus_wdata[7:0];
                            tbl_d[i].dmode       = bus_wdata[10:8];
                            tbl_d[i].dst_logical = bus_wdata[11];
                            tbl_d[i].pol         = bus_wdata[13];
                            tbl_d[i].level       = bus_wdata[15];
                            tbl_d[i].mask        = bus_wdata[16];
                        end
                    end
                end
            end
        end

        // end-of-interrupt: vector-matched remote-acknowledge clear
        for (int i = 0; i < NUM_LINES; i++) begin
            if (eoi_valid && tbl_q[i].rack && tbl_q[i].vec == eoi_vector)
                tbl_d[i].rack = 1'b0;
        end

        // delivery port
        if (ctl_q.dv && dlv_ready) ctl_d.dv = 1'b0;
        if (launch) begin
            ctl_d.dv              = 1'b1;
            ctl_d.msg.dest        = tbl_q[pick_idx].dest;
            ctl_d.msg.dst_logical = tbl_q[pick_idx].dst_logical;
            ctl_d.msg.dmode       = tbl_q[pick_idx].dmode;
            ctl_d.msg.vec         = tbl_q[pick_idx].vec;
            ctl_d.msg.level       = tbl_q[pick_idx].level;
            if (tbl_q[pick_idx].level) tbl_d[pick_idx].rack = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            irr_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) tbl_q[i] <= entry_rst();
        end else begin
            ctl_q <= ctl_d;
            irr_q <= irr_d;
            for (int i = 0; i < NUM_LINES; i++) tbl_q[i] <= tbl_d[i];
        end
    end

    assign bus_rdata     = ctl_q.rdata;
    assign dlv_valid     = ctl_q.dv;
    assign dlv_dest      = ctl_q.msg.dest;
    assign dlv_dest_mode = ctl_q.msg.dst_logical;
    assign dlv_mode      = ctl_q.msg.dmode;
    assign dlv_vector    = ctl_q.msg.vec;
    assign dlv_level     = ctl_q.msg.level;
endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
    parameter int NUM_LINES = 24,
    parameter int ADDR_W    = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_rd,
    input logic                 bus_word,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_rdata,
    input logic [7:0]           sel_q,
    input logic                 dlv_valid,
    input logic                 dlv_ready,
    input logic [7:0]           dlv_dest,
    input logic                 dlv_dest_mode,
    input logic [2:0]           dlv_mode,
    input logic [7:0]           dlv_vector,
    input logic                 dlv_level,
    input logic [NUM_LINES-1:0] grant,
    input logic [NUM_LINES-1:0] irr_q,
    input logic [NUM_LINES-1:0] mask_v,
    input logic [NUM_LINES-1:0] level_v
);
    logic win_rd;
    assign win_rd = bus_rd && bus_word && (bus_addr[7:0] == 8'h10);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_vector) && $stable(dlv_dest)
            && $stable(dlv_mode) && $stable(dlv_dest_mode) && $stable(dlv_level));

    assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_arb_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        win_rd && sel_q == 8'h02 |=> bus_rdata == 32'd0);

    assert_id_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
        win_rd && sel_q == 8'h00 |=> bus_rdata[31:28] == 4'd0 && bus_rdata[23:0] == 24'd0);

    assert_line0_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !irr_q[0]);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_edge
        assert_masked_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irr_q[i]) && !level_v[i] && !$past(level_v[i]) |-> !$past(mask_v[i]));
    end
endmodule

bind irq_redir_ctrl irq_redir_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_rd        (bus_rd),
    .bus_word      (bus_word),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .sel_q         (ctl_q.sel),
    .dlv_valid     (dlv_valid),
    .dlv_ready     (dlv_ready),
    .dlv_dest      (dlv_dest),
    .dlv_dest_mode (dlv_dest_mode),
    .dlv_mode      (dlv_mode),
    .dlv_vector    (dlv_vector),
    .dlv_level     (dlv_level),
    .grant         (grant),
    .irr_q         (irr_q),
    .mask_v        (mask_v),
    .level_v       (level_v)
);

// File: tb/tb_irq_redir_ctrl.sv
module tb_irq_redir_ctrl;
    localparam int N = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic [11:0]  bus_addr = '0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b1;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         eoi_valid = 1'b0;
    logic [7:0]   eoi_vector = '0;
    logic         dlv_valid, dlv_ready = 1'b1;
    logic [7:0]   dlv_dest, dlv_vector;
    logic         dlv_dest_mode, dlv_level;
    logic [2:0]   dlv_mode;

    int total = 0, bad = 0;
    bit done = 0;

    logic [7:0] m_vec, m_dest;
    logic [2:0] m_mode;
    logic       m_dm, m_lvl;

    always #10 clk = ~clk;

    irq_redir_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_dest(dlv_dest),
        .dlv_dest_mode(dlv_dest_mode), .dlv_mode(dlv_mode),
        .dlv_vector(dlv_vector), .dlv_level(dlv_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lo_word(input logic [7:0] vec, input logic [2:0] dm,
                                            input logic lg, input logic pol,
                                            input logic lvl, input logic msk);
        return {15'd0, msk, lvl, 1'b0, pol, 1'b0, lg, dm, vec};
    endfunction

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic w);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_word = w; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_word = 1'b1;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic w, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_word = w; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_word = 1'b1;
        d = bus_rdata;
    endtask

    task automatic win_write(input logic [7:0] idx, input logic [31:0] d);
        bus_write(12'h000, {24'd0, idx}, 1'b1);
        bus_write(12'h010, d, 1'b1);
    endtask

    task automatic win_read(input logic [7:0] idx, output logic [31:0] d);
        bus_write(12'h000, {24'd0, idx}, 1'b1);
        bus_read(12'h010, 1'b1, d);
    endtask

    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic get_msg(output logic ok);
        ok = 1'b0;
        for (int k = 0; k < 8 && !ok; k++) begin
            @(negedge clk);
            if (dlv_valid) begin
                ok = 1'b1;
                m_vec = dlv_vector; m_dest = dlv_dest; m_mode = dlv_mode;
                m_dm = dlv_dest_mode; m_lvl = dlv_level;
            end
        end
    endtask

    task automatic count_msgs(input int cycles, output int cnt);
        cnt = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (dlv_valid) cnt++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, e;
        logic        ok;
        int          cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13 reset state
        check("R13 valid", {31'd0, dlv_valid}, 32'd0);
        bus_read(12'h000, 1'b1, d);
        check("R13 select", d, 32'd0);
        win_read(8'h00, d);
        check("R13 id", d, 32'd0);
        win_read(8'h16, d);
        check("R13 entry lo", d, 32'h0001_0000);
        win_read(8'h17, d);
        check("R13 entry hi", d, 32'd0);

        // R10 identification, version, arbitration
        win_write(8'h00, 32'hFFFF_FFFF);
        win_read(8'h00, d);
        check("R10 id mask", d, 32'h0F00_0000);
        win_write(8'h00, 32'h0A00_0000);
        win_read(8'h00, d);
        check("R10 id", d, 32'h0A00_0000);
        win_write(8'h01, 32'hFFFF_FFFF);
        win_read(8'h01, d);
        check("R10 version", d, {8'd0, 8'(N - 1), 8'd0, 8'h20});
        win_write(8'h02, 32'hFFFF_FFFF);
        win_read(8'h02, d);
        check("R10 arb", d, 32'd0);

        // R11 readback sweep with half preservation (entries masked throughout)
        for (int n = 0; n < N; n++) begin
            logic [31:0] plo, phi;
            plo = (32'hA5A5_3C3C ^ (n * 32'h0001_3579)) | 32'h0001_0000;
            phi = 32'h5A00_0000 ^ (n * 32'h0B13_0000);
            win_write(8'(16 + 2 * n), plo);
            win_write(8'(17 + 2 * n), phi);
            win_read(8'(16 + 2 * n), d);
            check("R11 lo kept", d, plo & 32'h0001_AFFF);
            win_read(8'(17 + 2 * n), d);
            check("R11 hi", d, phi & 32'hFF00_0000);
        end
        for (int n = 0; n < N; n++) begin
            win_write(8'(16 + 2 * n), 32'h0001_0000);
            win_write(8'(17 + 2 * n), 32'd0);
        end

        // R11 select readback and address aliasing
        bus_write(12'hF00, 32'h0000_0033, 1'b1);
        bus_read(12'h000, 1'b1, d);
        check("R11 select alias", d, 32'h33);
        bus_read(12'hA10, 1'b1, d);
        check("R11 window alias", d, 32'd0);

        // R12 out of range and other offsets
        win_read(8'h40, d);
        check("R12 past table", d, 32'd0);
        win_read(8'h0F, d);
        check("R12 gap index", d, 32'd0);
        win_read(8'h03, d);
        check("R12 gap index 3", d, 32'd0);
        bus_read(12'h004, 1'b1, d);
        check("R12 other offset", d, 32'd0);

        // R6 R8 R3 delivery sweep: one message per edge, fields from entry
        for (int n = 1; n < N; n++) begin
            win_write(8'(17 + 2 * n), {8'(n * 3), 24'd0});
            win_write(8'(16 + 2 * n), lo_word(8'(32 + n), 3'(n % 8), n[0], 1'b0, 1'b0, 1'b0));
            @(negedge clk);
            irq_in[(n == 2) ? 0 : n] = 1'b1;
            get_msg(ok);
            check("R8 delivered", {31'd0, ok}, 32'd1);
            check("R6 vector", {24'd0, m_vec}, 32'(32 + n));
            check("R6 dest", {24'd0, m_dest}, 32'(8'(n * 3)));
            check("R6 mode", {28'd0, m_dm, m_mode}, {28'd0, n[0], 3'(n % 8)});
            check("R6 trigger", {31'd0, m_lvl}, 32'd0);
            count_msgs(4, cnt);
            check("R8 once per edge", cnt, 0);
            irq_in = '0;
        end
        // R3 input 2 also reaches line 2
        @(negedge clk);
        irq_in[2] = 1'b1;
        get_msg(ok);
        check("R3 input2 vector", {23'd0, ok, m_vec}, {23'd0, 1'b1, 8'h22});
        irq_in = '0;
        // R3 line 0 never requests, even when set up to be active
        win_write(8'h10, lo_word(8'h77, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0));
        count_msgs(6, cnt);
        check("R3 line0 silent", cnt, 0);
        win_write(8'h10, 32'h0001_0000);

        // R5 R9 ascending order with back-pressure
        @(negedge clk);
        dlv_ready = 1'b0;
        irq_in[9] = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 first", {23'd0, dlv_valid, dlv_vector}, {23'd0, 1'b1, 8'h29});
        irq_in[7] = 1'b1; irq_in[4] = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 held", {23'd0, dlv_valid, dlv_vector}, {23'd0, 1'b1, 8'h29});
        dlv_ready = 1'b1;
        get_msg(ok);
        check("R5 second", {23'd0, ok, m_vec}, {23'd0, 1'b1, 8'h24});
        get_msg(ok);
        check("R5 third", {23'd0, ok, m_vec}, {23'd0, 1'b1, 8'h27});
        irq_in = '0;
        count_msgs(4, cnt);
        check("R5 drained", cnt, 0);

        // R7 level line with remote acknowledge
        win_write(8'h1A, lo_word(8'h45, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        @(negedge clk);
        irq_in[5] = 1'b1;
        get_msg(ok);
        check("R7 level msg", {22'd0, ok, m_lvl, m_vec}, {22'd0, 1'b1, 1'b1, 8'h45});
        count_msgs(5, cnt);
        check("R7 no repeat", cnt, 0);
        win_read(8'h1A, d);
        check("R7 ack visible", d, 32'h0000_C045);
        send_eoi(8'h44);
        count_msgs(5, cnt);
        check("R7 wrong vector", cnt, 0);
        send_eoi(8'h45);
        get_msg(ok);
        check("R7 redeliver", {23'd0, ok, m_vec}, {23'd0, 1'b1, 8'h45});
        irq_in[5] = 1'b0;
        send_eoi(8'h45);
        count_msgs(5, cnt);
        check("R7 inactive after eoi", cnt, 0);

        // R2 level request lost when input drops while masked
        win_write(8'h1A, lo_word(8'h45, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1));
        @(negedge clk);
        irq_in[5] = 1'b1;
        repeat (3) @(negedge clk);
        irq_in[5] = 1'b0;
        repeat (2) @(negedge clk);
        win_write(8'h1A, lo_word(8'h45, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        count_msgs(5, cnt);
        check("R2 request follows input", cnt, 0);
        win_write(8'h1A, 32'h0001_0000);

        // R1 inverted edge line
        @(negedge clk);
        irq_in[6] = 1'b1;
        win_write(8'h1C, lo_word(8'h26, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0));
        count_msgs(4, cnt);
        check("R1 idle high quiet", cnt, 0);
        irq_in[6] = 1'b0;
        get_msg(ok);
        check("R1 falling fires", {23'd0, ok, m_vec}, {23'd0, 1'b1, 8'h26});
        irq_in[6] = 1'b1;
        count_msgs(5, cnt);
        check("R1 rising quiet", cnt, 0);
        win_write(8'h1C, 32'h0001_0000);
        irq_in[6] = 1'b0;

        // R4 masked edge dropped
        win_write(8'h20, lo_word(8'h28, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
        @(negedge clk);
        irq_in[8] = 1'b1;
        repeat (2) @(negedge clk);
        irq_in[8] = 1'b0;
        win_write(8'h20, lo_word(8'h28, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        count_msgs(5, cnt);
        check("R4 masked dropped", cnt, 0);

        // R12 narrow window accesses
        bus_write(12'h000, 32'h16, 1'b1);
        bus_read(12'h010, 1'b0, d);
        check("R12 narrow read", d, 32'd0);
        bus_write(12'h010, 32'h0000_0033, 1'b0);
        win_read(8'h16, d);
        e = lo_word(8'h23, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R12 narrow write", d, e);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule